// File: doc/BRIEF.md
# Local interrupt request acceptance unit

This block sits at the entry of a processor-local interrupt controller and takes in one interrupt request per clock. Each request brings an 8-bit vector, a 3-bit delivery mode and a trigger type (level or edge). Fixed and lowest-priority requests are recorded as bits in a 256-bit request bitmap. A companion trigger bitmap remembers the trigger type of each recorded vector, and a register tracks the highest vector requested so far.

Four special delivery modes skip the bitmap: system management, non-maskable, init and external. Each of them has a single-entry slot that holds a pending flag and the captured vector. The first request into an empty slot wins, and later ones are dropped until the delivery side clears the slot with its strobe. The system-management, non-maskable and init slots also drive a combined unmaskable-pending flag.

Top module: `irq_accept`

## Requirements
- R1: A valid request with mode 000 (fixed) or 001 (lowest priority) sets bit `vector` of `req_bits_o` on the clock edge that accepts it.
- R2: For modes 000 and 001, `top_vec_o` takes the incoming vector when that vector is larger than its current value, and otherwise keeps its value.
- R3: When bit `vector` of `req_bits_o` was clear, a mode 000/001 request writes bit `vector` of `trig_bits_o`: 1 when `req_level_i` is high, 0 when it is low.
- R4: A mode 000/001 request whose bit in `req_bits_o` is already set leaves `req_bits_o` and `trig_bits_o` unchanged.
- R5: Requests with reserved modes 011 or 110 change no output.
- R6: A request with mode 010 (system management), 100 (non-maskable) or 101 (init) sets that slot's pending flag, stores the vector in the slot, and raises `unmask_pend_o`.
- R7: A request with mode 111 (external) sets `ext_pend_o` and stores the vector in `ext_vec_o`, and does not raise `unmask_pend_o`.
- R8: A special-mode request that arrives while its slot is pending is ignored, so the slot keeps its first captured vector.
- R9: A clear strobe drops its slot's pending flag on the next edge. `unmask_pend_o` stays high while any of the system-management, non-maskable or init flags is set, and falls once none is.
- R10: After reset all pending flags, `unmask_pend_o`, both bitmaps and `top_vec_o` are zero.
- R11: While `req_valid_i` is low, the vector, mode and trigger inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe that qualifies vector, mode and trigger |
| req_vector_i | input | 8 | Request vector |
| req_mode_i | input | 3 | Delivery mode code |
| req_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| smi_clr_i | input | 1 | Clears the system-management slot |
| nmi_clr_i | input | 1 | Clears the non-maskable slot |
| init_clr_i | input | 1 | Clears the init slot |
| ext_clr_i | input | 1 | Clears the external slot |
| req_bits_o | output | 256 | Request bitmap |
| trig_bits_o | output | 256 | Trigger-type bitmap |
| top_vec_o | output | 8 | Highest vector requested |
| smi_pend_o | output | 1 | System-management slot pending |
| smi_vec_o | output | 8 | System-management captured vector |
| nmi_pend_o | output | 1 | Non-maskable slot pending |
| nmi_vec_o | output | 8 | Non-maskable captured vector |
| init_pend_o | output | 1 | Init slot pending |
| init_vec_o | output | 8 | Init captured vector |
| ext_pend_o | output | 1 | External slot pending |
| ext_vec_o | output | 8 | External captured vector |
| unmask_pend_o | output | 1 | Any system-management, non-maskable or init slot pending |

## Verification
The reserved-mode property assumes that no clear strobe arrives in the same cycle as the reserved request. The slot-hold property assumes that a pending slot changes only through its own clear. The bench keeps to both by pulsing clears only in cycles with no request. Requests are single-cycle strobes driven on the falling edge, so every acceptance falls on a known rising edge, and repeats into filled slots and filled bitmap bits are applied on purpose.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int VEC_W     = 8;
  localparam int NUM_SLOTS = 4;

  typedef enum logic [2:0] {
    MODE_FIXED  = 3'b000,
    MODE_LOWPRI = 3'b001,
    MODE_SMI    = 3'b010,
    MODE_RSV3   = 3'b011,
    MODE_NMI    = 3'b100,
    MODE_INIT   = 3'b101,
    MODE_RSV6   = 3'b110,
    MODE_EXT    = 3'b111
  } dmode_e;

  // slot index -> mode; slots 0..2 count toward the unmaskable flag
  function automatic dmode_e slot_mode(input int idx);
    case (idx)
      0:       return MODE_SMI;
      1:       return MODE_NMI;
      2:       return MODE_INIT;
      default: return MODE_EXT;
    endcase
  endfunction
endpackage

// File: rtl/irq_vec_bank.sv
module irq_vec_bank #(
  parameter int VEC_W = 8,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic               level_i,
  output logic [NUM_VEC-1:0] req_o,
  output logic [NUM_VEC-1:0] trig_o,
  output logic [VEC_W-1:0]   top_o
);
  logic [NUM_VEC-1:0] req_q, trig_q;
  logic [VEC_W-1:0]   top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      trig_q <= '0;
    end else if (take_i && !req_q[vec_i]) begin
      req_q[vec_i]  <= 1'b1;
      trig_q[vec_i] <= level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       top_q <= '0;
    else if (take_i && vec_i > top_q)  top_q <= vec_i;
  end

  assign req_o  = req_q;
  assign trig_o = trig_q;
  assign top_o  = top_q;

  // R1
  bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> req_q[$past(vec_i)]);

  // R2
  top_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> top_q >= $past(vec_i) && top_q >= $past(top_q));

  // R3
  trig_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !req_q[vec_i] |=> trig_q[$past(vec_i)] == $past(level_i));

  // R4
  repeat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && req_q[vec_i] |=> $stable(req_q) && $stable(trig_q));
endmodule

// File: rtl/irq_slot.sv
module irq_slot #(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             clr_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             pend_o,
  output logic             pend_nx_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             pend_q, pend_d;
  logic [VEC_W-1:0] vec_q;

  // a pending slot only leaves through its clear; an empty one fills on take
  assign pend_d = pend_q ? !clr_i : take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (take_i && !pend_q) vec_q <= vec_i;
    end
  end

  assign pend_o    = pend_q;
  assign pend_nx_o = pend_d;
  assign vec_o     = vec_q;

  // R8
  first_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> pend_q && $stable(vec_q));

  // R9
  clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && clr_i |=> !pend_q);

  // R6
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !pend_q |=> pend_q && vec_q == $past(vec_i));
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_accept_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_valid_i,
  input  logic [7:0]   req_vector_i,
  input  logic [2:0]   req_mode_i,
  input  logic         req_level_i,
  input  logic         smi_clr_i,
  input  logic         nmi_clr_i,
  input  logic         init_clr_i,
  input  logic         ext_clr_i,
  output logic [255:0] req_bits_o,
  output logic [255:0] trig_bits_o,
  output logic [7:0]   top_vec_o,
  output logic         smi_pend_o,
  output logic [7:0]   smi_vec_o,
  output logic         nmi_pend_o,
  output logic [7:0]   nmi_vec_o,
  output logic         init_pend_o,
  output logic [7:0]   init_vec_o,
  output logic         ext_pend_o,
  output logic [7:0]   ext_vec_o,
  output logic         unmask_pend_o
);
  localparam int NUM_UNMASK = NUM_SLOTS - 1;

  logic                 bank_take;
  logic [NUM_SLOTS-1:0] slot_clr, slot_pend, slot_nx;
  logic [VEC_W-1:0]     slot_vec [NUM_SLOTS];
  logic                 unmask_q;

  assign bank_take = req_valid_i &&
                     (req_mode_i == MODE_FIXED || req_mode_i == MODE_LOWPRI);
  assign slot_clr  = {ext_clr_i, init_clr_i, nmi_clr_i, smi_clr_i};

  irq_vec_bank #(.VEC_W(VEC_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (bank_take),
    .vec_i   (req_vector_i),
    .level_i (req_level_i),
    .req_o   (req_bits_o),
    .trig_o  (trig_bits_o),
    .top_o   (top_vec_o)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic take;
    assign take = req_valid_i && (req_mode_i == slot_mode(s));
    irq_slot #(.VEC_W(VEC_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .take_i    (take),
      .clr_i     (slot_clr[s]),
      .vec_i     (req_vector_i),
      .pend_o    (slot_pend[s]),
      .pend_nx_o (slot_nx[s]),
      .vec_o     (slot_vec[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) unmask_q <= 1'b0;
    else         unmask_q <= |slot_nx[NUM_UNMASK-1:0];
  end

  assign smi_pend_o    = slot_pend[0];
  assign smi_vec_o     = slot_vec[0];
  assign nmi_pend_o    = slot_pend[1];
  assign nmi_vec_o     = slot_vec[1];
  assign init_pend_o   = slot_pend[2];
  assign init_vec_o    = slot_vec[2];
  assign ext_pend_o    = slot_pend[3];
  assign ext_vec_o     = slot_vec[3];
  assign unmask_pend_o = unmask_q;

  // R5
  reserved_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_mode_i == MODE_RSV3 || req_mode_i == MODE_RSV6) && !(|slot_clr)
    |=> $stable(req_bits_o) && $stable(trig_bits_o) && $stable(top_vec_o) && $stable(slot_pend));

  // R6
  unmask_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unmask_q) |-> smi_pend_o || nmi_pend_o || init_pend_o);

  // R7
  ext_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_pend_o && !smi_pend_o && !nmi_pend_o && !init_pend_o |-> !unmask_q);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(req_bits_o) && $stable(top_vec_o));
endmodule

// File: tb/irq_accept_tb.sv
module irq_accept_tb;
  logic         clk = 0, rst_ni = 0;
  logic         req_valid = 0, req_level = 0;
  logic [7:0]   req_vector = 0;
  logic [2:0]   req_mode = 0;
  logic         smi_clr = 0, nmi_clr = 0, init_clr = 0, ext_clr = 0;
  logic [255:0] req_bits, trig_bits;
  logic [7:0]   top_vec, smi_vec, nmi_vec, init_vec, ext_vec;
  logic         smi_pend, nmi_pend, init_pend, ext_pend, unmask_pend;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_accept u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_vector_i(req_vector),
    .req_mode_i(req_mode), .req_level_i(req_level),
    .smi_clr_i(smi_clr), .nmi_clr_i(nmi_clr), .init_clr_i(init_clr), .ext_clr_i(ext_clr),
    .req_bits_o(req_bits), .trig_bits_o(trig_bits), .top_vec_o(top_vec),
    .smi_pend_o(smi_pend), .smi_vec_o(smi_vec), .nmi_pend_o(nmi_pend), .nmi_vec_o(nmi_vec),
    .init_pend_o(init_pend), .init_vec_o(init_vec), .ext_pend_o(ext_pend), .ext_vec_o(ext_vec),
    .unmask_pend_o(unmask_pend)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // one-cycle request; outputs are settled at the returning negedge
  task automatic send(input logic [7:0] v, input logic [2:0] m, input logic lvl);
    @(negedge clk);
    req_valid = 1; req_vector = v; req_mode = m; req_level = lvl;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic pulse_clr(input int which);
    @(negedge clk);
    case (which)
      0: smi_clr = 1;
      1: nmi_clr = 1;
      2: init_clr = 1;
      default: ext_clr = 1;
    endcase
    @(negedge clk);
    smi_clr = 0; nmi_clr = 0; init_clr = 0; ext_clr = 0;
  endtask

  function automatic logic [255:0] flags();
    return {unmask_pend, ext_pend, init_pend, nmi_pend, smi_pend,
            ext_vec, init_vec, nmi_vec, smi_vec, top_vec};
  endfunction

  task automatic t_reset();
    check("R10 req bits", req_bits, '0);
    check("R10 trig bits", trig_bits, '0);
    check("R10 top/flags", flags(), '0);
  endtask

  task automatic t_bitmap();
    send(8'h40, 3'b000, 1);
    check("R1 bit 40", req_bits, 256'h1 << 8'h40);
    check("R3 level", trig_bits, 256'h1 << 8'h40);
    check("R2 top 40", top_vec, 8'h40);
    send(8'h20, 3'b001, 0);
    check("R1 lowpri bit 20", req_bits[8'h20], 1);
    check("R3 edge", trig_bits[8'h20], 0);
    check("R2 smaller keeps", top_vec, 8'h40);
    send(8'hFF, 3'b000, 0);
    check("R2 top FF", top_vec, 8'hFF);
    send(8'h00, 3'b001, 1);
    check("R1 bit 0", req_bits[0], 1);
    check("R3 bit 0 level", trig_bits[0], 1);
    check("R2 zero keeps", top_vec, 8'hFF);
  endtask

  task automatic t_repeat();
    logic [255:0] r, t;
    r = req_bits; t = trig_bits;
    send(8'h40, 3'b000, 0);
    check("R4 req hold", req_bits, r);
    check("R4 trig kept level", trig_bits, t);
    send(8'h20, 3'b001, 1);
    check("R4 trig kept edge", trig_bits[8'h20], 0);
  endtask

  task automatic t_reserved();
    logic [255:0] r, t, f;
    r = req_bits; t = trig_bits; f = flags();
    send(8'h80, 3'b011, 1);
    send(8'h81, 3'b110, 0);
    check("R5 req", req_bits, r);
    check("R5 trig", trig_bits, t);
    check("R5 flags", flags(), f);
  endtask

  task automatic t_idle();
    logic [255:0] r, f;
    r = req_bits; f = flags();
    @(negedge clk);
    req_vector = 8'h90; req_mode = 3'b000; req_level = 1;
    @(negedge clk);
    req_mode = 3'b010;
    @(negedge clk);
    check("R11 req", req_bits, r);
    check("R11 flags", flags(), f);
  endtask

  task automatic t_special();
    send(8'h55, 3'b111, 0);
    check("R7 ext pend", ext_pend, 1);
    check("R7 ext vec", ext_vec, 8'h55);
    check("R7 no unmask", unmask_pend, 0);
    send(8'h11, 3'b010, 0);
    check("R6 smi pend", smi_pend, 1);
    check("R6 smi vec", smi_vec, 8'h11);
    check("R6 unmask", unmask_pend, 1);
    send(8'h22, 3'b010, 0);
    check("R8 smi keeps", smi_vec, 8'h11);
    send(8'h56, 3'b111, 0);
    check("R8 ext keeps", ext_vec, 8'h55);
    send(8'h33, 3'b100, 0);
    check("R6 nmi", {nmi_pend, nmi_vec}, {1'b1, 8'h33});
    send(8'h44, 3'b101, 0);
    check("R6 init", {init_pend, init_vec}, {1'b1, 8'h44});
  endtask

  task automatic t_clear();
    pulse_clr(0);
    check("R9 smi cleared", smi_pend, 0);
    check("R9 unmask held", unmask_pend, 1);
    pulse_clr(1);
    check("R9 unmask held init", unmask_pend, 1);
    pulse_clr(2);
    check("R9 unmask drop", unmask_pend, 0);
    pulse_clr(3);
    check("R9 ext cleared", ext_pend, 0);
    send(8'h66, 3'b010, 0);
    check("R9 refill", {smi_pend, smi_vec, unmask_pend}, {1'b1, 8'h66, 1'b1});
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_bitmap();
    t_repeat();
    t_reserved();
    t_idle();
    t_special();
    t_clear();
    summary();
  end
endmodule